// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block holds an alarm time as a set of BCD fields that mirror a live calendar: seconds, minutes, hours, weekday, day of month, month and year. Each field has its own participation flag, so software can build an alarm that ignores some fields, for example one that fires on a given date and time regardless of the weekday. On every second tick the enabled alarm fields are compared with the calendar values that the surrounding counter presents. A full match of every enabled field latches a pending status bit. The interrupt output is that status gated by an interrupt enable.

Software programs the alarm through a simple single-cycle register port. Field writes land in staging registers and have no effect until a commit write to the trigger register copies all staged fields into the active set at once. This keeps the compare from ever seeing a half-written alarm. Reads of a field address return the active field. The status bit is cleared by writing a one to it.

Top module: `alarm_cmp`

## Requirements
- R1: After reset the interrupt enable (address 8, bit 0), the status (address 9, bit 0), `irq_o` and every active field (value and enable flag) read as zero.
- R2: Field registers sit at addresses 0 to 6 in the order seconds, minutes, hours, weekday, day, month, year, with value widths 7, 7, 6, 3, 6, 5 and 8 bits in bits [w-1:0] and the participation flag in bit 15. A read of a field returns the active flag in bit 15, the active value masked to its width, and zeros elsewhere.
- R3: A field write changes only the staged copy. Writing address 7 with bit 15 set copies all seven staged fields to the active set in that cycle. A write to address 7 with bit 15 clear commits nothing.
- R4: On a cycle with `tick_i` high, if every enabled active field equals its calendar input, the status bit is set at that clock edge.
- R5: Fields whose flag is clear take no part in the match, so a mismatch in a disabled field does not stop the alarm.
- R6: With no field enabled, a tick never sets the status bit.
- R7: Without `tick_i` the status bit is never set, whatever the calendar inputs.
- R8: `irq_o` is high exactly while both the status bit and the interrupt enable bit are set.
- R9: Writing address 9 with bit 0 set clears the status; writing it with bit 0 clear has no effect. The status stays set while the interrupt enable is dropped.
- R10: A match on the same cycle as a status clear write leaves the status set.
- R11: A mismatch in any single enabled field prevents the status from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second, calendar already updated |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 6 | Calendar hours, BCD |
| cal_wday_i | input | 3 | Calendar weekday |
| cal_day_i | input | 6 | Calendar day of month, BCD |
| cal_mon_i | input | 5 | Calendar month, BCD |
| cal_year_i | input | 8 | Calendar year, BCD |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for write and read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The bench builds the block with its default 4-bit address and 16-bit data widths, which puts the flag at bit 15 and leaves addresses 10 to 15 unused, so every field, the commit register and both interrupt registers are reachable. One programmed alarm with weekday disabled is run against a table of calendar inputs that differ from it in one field at a time, which exercises every per-field comparator in both directions. Directed cases cover width masking on readback, the staged-versus-active split, an empty enable set, ticks withheld, and the collision of a match with a clear write.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_W_MAX = 8;
  localparam int EN_BIT      = 15;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_DAY  = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  localparam int ADDR_TRIG = 7;
  localparam int ADDR_IEN  = 8;
  localparam int ADDR_ISTA = 9;

  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction

  function automatic logic [FIELD_W_MAX-1:0] field_mask(input int idx);
    return FIELD_W_MAX'((1 << field_width(idx)) - 1);
  endfunction

  typedef logic [NUM_FIELDS-1:0][FIELD_W_MAX-1:0] field_vec_t;
endpackage

// File: rtl/alarm_field_regs.sv
module alarm_field_regs
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output field_vec_t            act_val_o,
  output logic [NUM_FIELDS-1:0] act_en_o,
  output logic                  commit_o
);
  logic [FIELD_W_MAX-1:0] wval;
  logic                   unused_wdata;

  assign wval         = wdata_i[FIELD_W_MAX-1:0];
  assign unused_wdata = ^wdata_i;
  assign commit_o     = wr_en_i && (addr_i == ADDR_W'(ADDR_TRIG)) && wdata_i[EN_BIT];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [FIELD_W_MAX-1:0] MASK = field_mask(g);
    logic                   stg_en_q;
    logic [FIELD_W_MAX-1:0] stg_val_q;
    logic                   sel;

    assign sel = wr_en_i && (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_en_q  <= 1'b0;
        stg_val_q <= '0;
      end else if (sel) begin
        stg_en_q  <= wdata_i[EN_BIT];
        stg_val_q <= wval & MASK;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_en_o[g]  <= 1'b0;
        act_val_o[g] <= '0;
      end else if (commit_o) begin
        act_en_o[g]  <= stg_en_q;
        act_val_o[g] <= stg_val_q;
      end
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_cmp_pkg::*;
(
  input  field_vec_t            cal_val_i,
  input  field_vec_t            act_val_i,
  input  logic [NUM_FIELDS-1:0] act_en_i,
  output logic                  hit_o
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    localparam logic [FIELD_W_MAX-1:0] MASK = field_mask(g);
    assign field_ok[g] = !act_en_i[g] || ((cal_val_i[g] & MASK) == act_val_i[g]);
  end

  // empty enable set must never fire
  assign hit_o = (|act_en_i) && (&field_ok);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int IEN_ADDR  = 8,
  parameter int ISTA_ADDR = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ien_o,
  output logic              status_o,
  output logic              irq_o
);
  logic set_ev, clr_ev;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];
  assign set_ev = tick_i && hit_i;
  assign clr_ev = wr_en_i && (addr_i == ADDR_W'(ISTA_ADDR)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= 1'b0;
    end else if (wr_en_i && (addr_i == ADDR_W'(IEN_ADDR))) begin
      ien_o <= wdata_i[0];
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_o <= 1'b0;
    else if (set_ev) status_o <= 1'b1;
    else if (clr_ev) status_o <= 1'b0;
  end

  assign irq_o = status_o & ien_o;
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        cal_sec_i,
  input  logic [6:0]        cal_min_i,
  input  logic [5:0]        cal_hour_i,
  input  logic [2:0]        cal_wday_i,
  input  logic [5:0]        cal_day_i,
  input  logic [4:0]        cal_mon_i,
  input  logic [7:0]        cal_year_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  field_vec_t            cal_val, act_val;
  logic [NUM_FIELDS-1:0] act_en;
  logic                  commit, hit, ien_q, status_q;

  always_comb begin
    cal_val         = '0;
    cal_val[F_SEC]  = FIELD_W_MAX'(cal_sec_i);
    cal_val[F_MIN]  = FIELD_W_MAX'(cal_min_i);
    cal_val[F_HOUR] = FIELD_W_MAX'(cal_hour_i);
    cal_val[F_WDAY] = FIELD_W_MAX'(cal_wday_i);
    cal_val[F_DAY]  = FIELD_W_MAX'(cal_day_i);
    cal_val[F_MON]  = FIELD_W_MAX'(cal_mon_i);
    cal_val[F_YEAR] = cal_year_i;
  end

  alarm_field_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .act_val_o (act_val),
    .act_en_o  (act_en),
    .commit_o  (commit)
  );

  alarm_match u_match (
    .cal_val_i (cal_val),
    .act_val_i (act_val),
    .act_en_i  (act_en),
    .hit_o     (hit)
  );

  alarm_irq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IEN_ADDR(ADDR_IEN), .ISTA_ADDR(ADDR_ISTA)
  ) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .hit_i    (hit),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ien_o    (ien_q),
    .status_o (status_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (addr_i == ADDR_W'(f)) begin
        rdata_o[EN_BIT]            = act_en[f];
        rdata_o[FIELD_W_MAX-1:0]   = act_val[f];
      end
    end
    if (addr_i == ADDR_W'(ADDR_IEN))  rdata_o[0] = ien_q;
    if (addr_i == ADDR_W'(ADDR_ISTA)) rdata_o[0] = status_q;
  end
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic                  irq_o,
  input logic                  status_i,
  input logic                  ien_i,
  input logic [NUM_FIELDS-1:0] act_en_i,
  input logic                  hit_i,
  input logic                  commit_i
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_ISTA)) && wdata_i[0];

  a_r9_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i && !clr_wr |=> status_i);
  a_r7_tick_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i && !tick_i |=> !status_i);
  a_r6_no_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i && (act_en_i == '0) |=> !status_i);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hit_i |=> status_i);
  a_r8_irq_needs_ien: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_i && status_i);
  a_r3_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_en_i));
endmodule

bind alarm_cmp alarm_cmp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .status_i (status_q),
  .ien_i    (ien_q),
  .act_en_i (act_en),
  .hit_i    (hit),
  .commit_i (commit)
);

// File: tb/sim_alarm_cmp.sv
`timescale 1ns/1ps
module sim_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [6:0]  c_sec = '0, c_min = '0;
  logic [5:0]  c_hour = '0, c_day = '0;
  logic [2:0]  c_wday = '0;
  logic [4:0]  c_mon = '0;
  logic [7:0]  c_year = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alarm_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cal_sec_i(c_sec), .cal_min_i(c_min), .cal_hour_i(c_hour),
    .cal_wday_i(c_wday), .cal_day_i(c_day), .cal_mon_i(c_mon),
    .cal_year_i(c_year), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // sec,min,hour,wday,day,mon,year,expected status
  localparam logic [43:0] VEC [9] = '{
    {7'h30, 7'h15, 6'h12, 3'd3, 6'h21, 5'h07, 8'h24, 1'b1},
    {7'h30, 7'h15, 6'h12, 3'd5, 6'h21, 5'h07, 8'h24, 1'b1},
    {7'h31, 7'h15, 6'h12, 3'd3, 6'h21, 5'h07, 8'h24, 1'b0},
    {7'h30, 7'h16, 6'h12, 3'd3, 6'h21, 5'h07, 8'h24, 1'b0},
    {7'h30, 7'h15, 6'h13, 3'd3, 6'h21, 5'h07, 8'h24, 1'b0},
    {7'h30, 7'h15, 6'h12, 3'd3, 6'h20, 5'h07, 8'h24, 1'b0},
    {7'h30, 7'h15, 6'h12, 3'd3, 6'h21, 5'h08, 8'h24, 1'b0},
    {7'h30, 7'h15, 6'h12, 3'd3, 6'h21, 5'h07, 8'h25, 1'b0},
    {7'h30, 7'h15, 6'h12, 3'd0, 6'h21, 5'h07, 8'h24, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_cal(input logic [43:0] v);
    {c_sec, c_min, c_hour, c_wday, c_day, c_mon, c_year} = v[43:1];
  endtask

  task automatic program_alarm();
    wr(4'd0, 16'h8030); wr(4'd1, 16'h8015); wr(4'd2, 16'h8012);
    wr(4'd3, 16'h0003); wr(4'd4, 16'h8021); wr(4'd5, 16'h8007);
    wr(4'd6, 16'h8024); wr(4'd7, 16'h8000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd8, d); chk("R1 ien", d, 16'h0000);
    rd(4'd9, d); chk("R1 status", d, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    for (int f = 0; f < 7; f++) begin
      rd(4'(f), d); chk("R1 field", d, 16'h0000);
    end

    // R2 width masking on readback
    wr(4'd0, 16'hFFFF); wr(4'd3, 16'hFFFF); wr(4'd5, 16'h7FFF); wr(4'd6, 16'hFFFF);
    // R3 staged only
    rd(4'd0, d); chk("R3 staged not active", d, 16'h0000);
    wr(4'd7, 16'h7FFF);
    rd(4'd0, d); chk("R3 trigger bit clear ignored", d, 16'h0000);
    wr(4'd7, 16'h8000);
    rd(4'd0, d); chk("R2 sec mask", d, 16'h807F);
    rd(4'd3, d); chk("R2 wday mask", d, 16'h8007);
    rd(4'd5, d); chk("R2 mon mask", d, 16'h001F);
    rd(4'd6, d); chk("R2 year", d, 16'h80FF);

    // main table: R4 R5 R11
    program_alarm();
    wr(4'd8, 16'h0001);
    for (int i = 0; i < 9; i++) begin
      set_cal(VEC[i]);
      pulse_tick();
      rd(4'd9, d); chk("R4/R5/R11 vector status", d, {15'b0, VEC[i][0]});
      chk("R8 irq follows status", {15'b0, irq}, {15'b0, VEC[i][0]});
      wr(4'd9, 16'h0001);
    end

    // R7 matching calendar without tick
    set_cal(VEC[0]);
    repeat (4) @(negedge clk);
    rd(4'd9, d); chk("R7 no tick", d, 16'h0000);

    // R9 write 0 no effect, persist with enable dropped, R8 gating
    pulse_tick();
    wr(4'd9, 16'h0000);
    rd(4'd9, d); chk("R9 write zero keeps status", d, 16'h0001);
    wr(4'd8, 16'h0000);
    rd(4'd9, d); chk("R9 status persists", d, 16'h0001);
    chk("R8 irq gated off", {15'b0, irq}, 16'h0000);
    wr(4'd8, 16'h0001);
    chk("R8 irq on", {15'b0, irq}, 16'h0001);
    wr(4'd9, 16'h0001);
    rd(4'd9, d); chk("R9 w1c clears", d, 16'h0000);

    // R10 match and clear in same cycle
    pulse_tick();
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd9; wdata = 16'h0001; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(4'd9, d); chk("R10 set wins", d, 16'h0001);
    wr(4'd9, 16'h0001);

    // R3 staged change does not alter compare until commit
    wr(4'd0, 16'h8045);
    pulse_tick();
    rd(4'd9, d); chk("R3 old alarm still active", d, 16'h0001);
    wr(4'd9, 16'h0001);

    // R6 no fields enabled
    for (int f = 0; f < 7; f++) wr(4'(f), 16'h0000);
    wr(4'd7, 16'h8000);
    pulse_tick();
    rd(4'd9, d); chk("R6 empty enable set", d, 16'h0000);
    chk("R6 irq", {15'b0, irq}, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule